// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recent virtual-to-physical page translations for a memory system that uses 8 KB pages. Because the page is 8 KB, the low 13 bits of any address pass through untouched and only the upper bits, the virtual page number (VPN), are offered here. A lookup returns, combinationally in the same cycle, a hit flag, the physical page number (PPN) and a fault flag that was recorded when the translation was installed. Any translation may be placed in any of the entries, and every entry is compared in parallel with the looked-up VPN.

When a lookup misses, a small controller raises a request to an external page-table walker and holds the missing VPN steady until the walker installs a translation through the fill port. The requester keeps presenting the same lookup; once the translation has been written, the retried lookup completes as a hit. When every entry is valid, the fill overwrites the least recently used one, tracked by a per-entry age counter that is refreshed on every hit and every install. A flush input invalidates every entry at once.

The controller has three states. `ST_IDLE`: lookups served, no walk pending. `ST_WALK`: a walk is outstanding and `miss_req` is high. `ST_RETRY`: the cycle after an install that ended a walk, in which the held lookup is reissued. Transitions: IDLE or RETRY to WALK on a valid lookup that misses with no flush; WALK to RETRY on a fill; WALK to IDLE on a flush; RETRY to IDLE when the reissued lookup hits or no lookup is present; IDLE and RETRY to IDLE on a flush.

Top module: `tlb_fa`

## Requirements
- R1: With `lookup_valid` high and a valid entry whose VPN equals `lookup_vpn`, `lookup_hit` is 1 and `lookup_ppn` shows that entry's PPN in the same cycle; with `lookup_valid` low, `lookup_hit` is 0.
- R2: `lookup_fault` equals the fault bit given with the fill of the entry that hits, and is 0 when there is no hit.
- R3: Any 16 distinct VPNs installed after a flush are all held together and all hit afterwards.
- R4: Installing a VPN that already has a valid entry overwrites that entry's PPN and fault bit and uses no second entry.
- R5: A valid lookup that misses in IDLE or RETRY with no flush makes `miss_req` go high on the next cycle with `miss_vpn` equal to the missing VPN; both stay unchanged until a fill or flush.
- R6: A fill installs its translation at the clock edge, so a lookup of that VPN in the next cycle hits; a fill during a walk makes `miss_req` low from the next cycle.
- R7: When all entries are valid, a fill replaces the entry that went longest without a hit or install.
- R8: While any entry is invalid, a fill of a new VPN goes into an invalid entry and evicts nothing.
- R9: `flush` invalidates every entry in one cycle; a lookup in the flush cycle misses, a fill in the flush cycle is ignored, and `miss_req` is low from the next cycle.
- R10: After reset no lookup hits and `miss_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lookup_valid | input | 1 | Lookup request present |
| lookup_vpn | input | VPN_W (19) | Virtual page number to translate |
| lookup_hit | output | 1 | Translation found (same cycle) |
| lookup_ppn | output | PPN_W (19) | Physical page number on hit, else 0 |
| lookup_fault | output | 1 | Stored fault bit of the hit entry |
| miss_req | output | 1 | Walk request to the page-table walker |
| miss_vpn | output | VPN_W (19) | VPN the walker must resolve |
| fill_valid | input | 1 | Walker installs a translation |
| fill_vpn | input | VPN_W (19) | VPN being installed |
| fill_ppn | input | PPN_W (19) | PPN being installed |
| fill_fault | input | 1 | Fault bit stored with the translation |

## Verification
Lookup results are combinational, so the bench drives a lookup after a falling edge and reads `lookup_hit`, `lookup_ppn` and `lookup_fault` one nanosecond later, within the same cycle. Fills and flushes act at the next rising edge, so their effect is read through a lookup in the following cycle. `miss_req` and `miss_vpn` come from a register and are due one cycle after the missing lookup; the bench samples them after the next falling edge, and checks that `miss_req` has dropped one cycle after a fill or flush.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WALK  = 2'd1,
        ST_RETRY = 2'd2
    } tlb_state_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int VPN_W   = 19,
    parameter int PPN_W   = 19,
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [VPN_W-1:0]   look_vpn,
    output logic [ENTRIES-1:0] look_match,
    output logic [PPN_W-1:0]   look_ppn,
    output logic               look_fault,
    input  logic [VPN_W-1:0]   probe_vpn,
    output logic [ENTRIES-1:0] probe_match,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [PPN_W-1:0]   wr_ppn,
    input  logic               wr_fault,
    output logic [ENTRIES-1:0] valid_vec
);
    logic [VPN_W-1:0] tag_q   [ENTRIES];
    logic [PPN_W-1:0] ppn_q   [ENTRIES];
    logic             fault_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;

    assign valid_vec = valid_q;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[e] <= 1'b0;
                tag_q[e]   <= '0;
                ppn_q[e]   <= '0;
                fault_q[e] <= 1'b0;
            end else if (flush) begin
                valid_q[e] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                valid_q[e] <= 1'b1;
                tag_q[e]   <= probe_vpn;
                ppn_q[e]   <= wr_ppn;
                fault_q[e] <= wr_fault;
            end
        end
        assign look_match[e]  = valid_q[e] && !flush && (tag_q[e] == look_vpn);
        assign probe_match[e] = valid_q[e] && (tag_q[e] == probe_vpn);
    end

    always_comb begin
        look_ppn   = '0;
        look_fault = 1'b0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (look_match[e]) begin
                look_ppn   = look_ppn | ppn_q[e];
                look_fault = look_fault | fault_q[e];
            end
        end
    end

    a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_match));
    a_r4_single_probe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(probe_match));
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] valid_vec,
    output logic [IDX_W-1:0]   victim_idx
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] age_q [ENTRIES];
    logic [IDX_W-1:0] touched_age;

    assign touched_age = age_q[touch_idx];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_age
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                age_q[e] <= IDX_W'(e);
            end else if (touch_en) begin
                if (touch_idx == IDX_W'(e))
                    age_q[e] <= '0;
                else if (age_q[e] < touched_age)
                    age_q[e] <= age_q[e] + 1'b1;
            end
        end
    end

    always_comb begin
        logic found;
        found      = 1'b0;
        victim_idx = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (!valid_vec[e] && !found) begin
                victim_idx = IDX_W'(e);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (age_q[e] == OLDEST) victim_idx = IDX_W'(e);
            end
        end
    end

    a_r7_touch_youngest: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> age_q[$past(touch_idx)] == '0);
    a_r8_victim_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_vec != '1) |-> !valid_vec[victim_idx]);
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import tlb_pkg::*;
#(
    parameter int VPN_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             look_req,
    input  logic             look_hit,
    input  logic [VPN_W-1:0] look_vpn,
    input  logic             fill_valid,
    output logic             miss_req,
    output logic [VPN_W-1:0] miss_vpn
);
    tlb_state_e state_q, state_d;
    logic [VPN_W-1:0] vpn_q;
    logic start_walk;

    assign start_walk = look_req && !look_hit && !flush;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_RETRY: begin
                if (flush)           state_d = ST_IDLE;
                else if (start_walk) state_d = ST_WALK;
                else                 state_d = ST_IDLE;
            end
            ST_WALK: begin
                if (flush)           state_d = ST_IDLE;
                else if (fill_valid) state_d = ST_RETRY;
            end
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vpn_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_WALK && start_walk) vpn_q <= look_vpn;
        end
    end

    always_comb begin
        miss_req = 1'b0;
        miss_vpn = vpn_q;
        unique case (state_q)
            ST_WALK:           miss_req = 1'b1;
            ST_IDLE, ST_RETRY: miss_req = 1'b0;
            default:           miss_req = 1'b0;
        endcase
    end

    a_r5_walk_held: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req && !fill_valid && !flush) |=> (miss_req && $stable(miss_vpn)));
    a_r5_walk_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!miss_req && look_req && !look_hit && !flush) |=> (miss_req && miss_vpn == $past(look_vpn)));
    a_r6_fill_ends_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req && fill_valid) |=> !miss_req);
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 13,
    parameter int ENTRIES   = 16,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PPN_W    = PA_W - PAGE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             lookup_valid,
    input  logic [VPN_W-1:0] lookup_vpn,
    output logic             lookup_hit,
    output logic [PPN_W-1:0] lookup_ppn,
    output logic             lookup_fault,
    output logic             miss_req,
    output logic [VPN_W-1:0] miss_vpn,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_fault
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] look_match, probe_match, valid_vec;
    logic [PPN_W-1:0]   cam_ppn;
    logic               cam_fault;
    logic [IDX_W-1:0]   victim_idx, hit_idx, dup_idx, wr_idx;
    logic               wr_en, touch_en;
    logic [IDX_W-1:0]   touch_idx;

    always_comb begin
        hit_idx = '0;
        dup_idx = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (look_match[e])  hit_idx = hit_idx | IDX_W'(e);
            if (probe_match[e]) dup_idx = dup_idx | IDX_W'(e);
        end
    end

    assign lookup_hit   = lookup_valid && (look_match != '0);
    assign lookup_ppn   = lookup_hit ? cam_ppn : '0;
    assign lookup_fault = lookup_hit && cam_fault;

    assign wr_en     = fill_valid && !flush;
    assign wr_idx    = (probe_match != '0) ? dup_idx : victim_idx;
    assign touch_en  = wr_en || lookup_hit;
    assign touch_idx = wr_en ? wr_idx : hit_idx;

    tlb_cam #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_cam (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .look_vpn(lookup_vpn), .look_match(look_match),
        .look_ppn(cam_ppn), .look_fault(cam_fault),
        .probe_vpn(fill_vpn), .probe_match(probe_match),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_ppn(fill_ppn), .wr_fault(fill_fault),
        .valid_vec(valid_vec)
    );

    tlb_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
        .clk(clk), .rst_n(rst_n),
        .touch_en(touch_en), .touch_idx(touch_idx),
        .valid_vec(valid_vec), .victim_idx(victim_idx)
    );

    tlb_ctrl #(.VPN_W(VPN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .look_req(lookup_valid), .look_hit(lookup_hit), .look_vpn(lookup_vpn),
        .fill_valid(fill_valid), .miss_req(miss_req), .miss_vpn(miss_vpn)
    );

    a_r9_flush_misses: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !lookup_hit);
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));
    a_r6_fill_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_vec[$past(wr_idx)]);
    a_r2_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_fault |-> lookup_hit);
endmodule

// File: tb/tlb_fa_test.sv
module tlb_fa_test;
    localparam int VPN_W = 19;
    localparam int PPN_W = 19;
    localparam int NV    = 14;
    localparam logic [1:0] OP_FILL = 2'd0, OP_LOOK = 2'd1, OP_FLUSH = 2'd2;

    // row: {op, vpn, ppn/expected ppn, fault/expected fault, expected hit}
    localparam logic [41:0] VEC [NV] = '{
        {OP_FILL,  19'h00010, 19'h00A00, 1'b0, 1'b0},
        {OP_FILL,  19'h00020, 19'h00B00, 1'b1, 1'b0},
        {OP_LOOK,  19'h00010, 19'h00A00, 1'b0, 1'b1},
        {OP_LOOK,  19'h00020, 19'h00B00, 1'b1, 1'b1},
        {OP_LOOK,  19'h00030, 19'h00000, 1'b0, 1'b0},
        {OP_FILL,  19'h00030, 19'h00C00, 1'b0, 1'b0},
        {OP_LOOK,  19'h00030, 19'h00C00, 1'b0, 1'b1},
        {OP_FILL,  19'h00010, 19'h00D00, 1'b1, 1'b0},
        {OP_LOOK,  19'h00010, 19'h00D00, 1'b1, 1'b1},
        {OP_FLUSH, 19'h00000, 19'h00000, 1'b0, 1'b0},
        {OP_LOOK,  19'h00020, 19'h00000, 1'b0, 1'b0},
        {OP_LOOK,  19'h7FFFF, 19'h00000, 1'b0, 1'b0},
        {OP_FILL,  19'h7FFFF, 19'h12345, 1'b1, 1'b0},
        {OP_LOOK,  19'h7FFFF, 19'h12345, 1'b1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0, lookup_valid = 1'b0, fill_valid = 1'b0, fill_fault = 1'b0;
    logic [VPN_W-1:0] lookup_vpn = '0, fill_vpn = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic lookup_hit, lookup_fault, miss_req;
    logic [PPN_W-1:0] lookup_ppn;
    logic [VPN_W-1:0] miss_vpn;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tlb_fa uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lookup_valid(lookup_valid), .lookup_vpn(lookup_vpn),
        .lookup_hit(lookup_hit), .lookup_ppn(lookup_ppn), .lookup_fault(lookup_fault),
        .miss_req(miss_req), .miss_vpn(miss_vpn),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_fault(fill_fault)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one cycle after a falling edge; inputs clear after the rising edge
    task automatic drive(input bit fl, input bit lv, input logic [VPN_W-1:0] lvpn,
                         input bit fv, input logic [VPN_W-1:0] fvpn,
                         input logic [PPN_W-1:0] fppn, input bit ff);
        @(negedge clk);
        flush = fl; lookup_valid = lv; lookup_vpn = lvpn;
        fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; fill_fault = ff;
        #1;
    endtask

    task automatic release_in();
        @(posedge clk); #1;
        flush = 0; lookup_valid = 0; fill_valid = 0;
    endtask

    task automatic fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p, input bit f);
        drive(0, 0, '0, 1, v, p, f);
        release_in();
    endtask

    task automatic look(input logic [VPN_W-1:0] v, input bit eh,
                        input logic [PPN_W-1:0] ep, input string tag);
        drive(0, 1, v, 0, '0, '0, 0);
        chk(lookup_hit == eh, tag, 32'(lookup_hit), 32'(eh));
        if (eh) chk(lookup_ppn == ep, tag, 32'(lookup_ppn), 32'(ep));
        release_in();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10: reset state
        drive(0, 1, 19'h00000, 0, '0, '0, 0);
        chk(!lookup_hit, "R10 no hit after reset", 32'(lookup_hit), 0);
        chk(!miss_req, "R10 miss_req low after reset", 32'(miss_req), 0);
        release_in();
        @(negedge clk);
        chk(miss_req && miss_vpn == 19'h0, "R5 walk raised after reset miss", 32'(miss_vpn), 0);
        drive(1, 0, '0, 0, '0, '0, 0);
        release_in();
        @(negedge clk);
        chk(!miss_req, "R9 flush drops miss_req", 32'(miss_req), 0);

        // vector table: R1 R2 R4 R6 R9
        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            logic [VPN_W-1:0] v;
            logic [PPN_W-1:0] p;
            logic f, eh;
            {op, v, p, f, eh} = VEC[i];
            unique case (op)
                OP_FILL:  drive(0, 0, '0, 1, v, p, f);
                OP_FLUSH: drive(1, 0, '0, 0, '0, '0, 0);
                default: begin
                    drive(0, 1, v, 0, '0, '0, 0);
                    chk(lookup_hit == eh, $sformatf("R1 row %0d hit", i), 32'(lookup_hit), 32'(eh));
                    if (eh) begin
                        chk(lookup_ppn == p, $sformatf("R1 row %0d ppn", i), 32'(lookup_ppn), 32'(p));
                        chk(lookup_fault == f, $sformatf("R2 row %0d fault", i), 32'(lookup_fault), 32'(f));
                    end
                end
            endcase
            release_in();
        end

        // R1: lookup_valid low never hits
        drive(0, 0, 19'h7FFFF, 0, '0, '0, 0);
        chk(!lookup_hit && !lookup_fault, "R1 idle port no hit", 32'(lookup_hit), 0);
        release_in();

        // R5/R6: miss handshake and retry
        drive(1, 0, '0, 0, '0, '0, 0); release_in();
        drive(0, 1, 19'h00444, 0, '0, '0, 0);
        chk(!miss_req, "R5 miss_req not yet", 32'(miss_req), 0);
        release_in();
        @(negedge clk);
        chk(miss_req && miss_vpn == 19'h00444, "R5 miss_vpn", 32'(miss_vpn), 32'h444);
        @(negedge clk);
        chk(miss_req && miss_vpn == 19'h00444, "R5 miss held", 32'(miss_req), 1);
        fill(19'h00444, 19'h00555, 0);
        chk(!miss_req, "R6 miss_req dropped after fill", 32'(miss_req), 0);
        look(19'h00444, 1, 19'h00555, "R6 retry hits");
        @(negedge clk);
        chk(!miss_req, "R6 no new walk after retry hit", 32'(miss_req), 0);

        // R9: lookup in flush cycle misses, fill in flush cycle ignored
        drive(1, 1, 19'h00444, 1, 19'h00666, 19'h00777, 0);
        chk(!lookup_hit, "R9 flush cycle lookup misses", 32'(lookup_hit), 0);
        release_in();
        look(19'h00666, 0, '0, "R9 fill during flush ignored");
        look(19'h00444, 0, '0, "R9 entry gone after flush");
        fill(19'h00001, 19'h0, 0); // ends walk started above

        // R3/R8/R4: after flush, duplicate then 15 more, all 16 held
        drive(1, 0, '0, 0, '0, '0, 0); release_in();
        fill(19'h01000, 19'h00100, 0);
        fill(19'h01000, 19'h00200, 1);
        for (int k = 1; k < 16; k++) fill(19'h01000 + 19'(k), 19'h00100 + 19'(k), 0);
        look(19'h01000, 1, 19'h00200, "R4 duplicate overwrote");
        for (int k = 1; k < 16; k++)
            look(19'h01000 + 19'(k), 1, 19'h00100 + 19'(k), "R3 R8 all sixteen held");

        // R7: LRU replacement
        drive(1, 0, '0, 0, '0, '0, 0); release_in();
        for (int k = 0; k < 16; k++) fill(19'h02000 + 19'(k), 19'h00300 + 19'(k), 0);
        look(19'h02000, 1, 19'h00300, "R7 refresh oldest");
        fill(19'h03000, 19'h00999, 0);
        look(19'h02001, 0, '0, "R7 least recent evicted");
        fill(19'h02001, 19'h00301, 0); // close walk; evicts 0x02002
        look(19'h02000, 1, 19'h00300, "R7 refreshed entry kept");
        look(19'h03000, 1, 19'h00999, "R7 new entry present");
        look(19'h02002, 0, '0, "R7 next oldest evicted");
        fill(19'h02002, 19'h00302, 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule